// File: doc/BRIEF.md
# DMA Transfer Request Staging Queue

This block sits between a source of transfer requests (a channel controller or a CPU register path) and the two halves of a DMA data mover. Each transfer request carries a source address, a destination address, a byte count and a tag. A request is written only into one staging slot, the program set. From there it is promoted in one step into two places: the single active context that drives the read engine, and the tail of a small context FIFO whose head drives the write engine.

Because the read and write sides are decoupled, the read engine can finish a transfer and start the next one while the write engine is still draining older ones. How far the read side can run ahead is bounded by the depth of the destination context FIFO, which is 2 or 4 entries. The program set carries an ownership flag. While a request sits in it, new requests are held off. When the write engine accepts the final beat of the transfer at the FIFO head, a completion carrying that transfer's tag is issued.

Top module: `tr_stage_queue`

## Requirements
- R1: After reset, `req_ready` is 1, and `prog_owned`, `rd_valid`, `wr_valid` and `cmpl_valid` are all 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. After that edge `prog_owned` is 1 and `req_ready` is 0.
- R3: While `prog_owned` is 1, `req_ready` is 0. A request offered in that time is not taken, and it never appears on the read or write outputs.
- R4: The read side is idle and the FIFO is not full. A request taken at edge k shows on both the read context and the write head after edge k+1, and `prog_owned` returns to 0 at that same edge.
- R5: A request waiting in the program set is promoted on the same edge at which `rd_done` is sampled high for the active context, so the read context changes with no idle cycle. The read context stays fixed while `rd_done` is low.
- R6: Promoted transfers join the destination FIFO in promotion order. The write head stays on the oldest unfinished transfer while the read side moves on.
- R7: Promotion stalls while the destination FIFO holds DFIFO_DEPTH entries, even if the read context is free. During the stall `prog_owned` stays 1.
- R8: A clock edge where `wr_valid` and `wr_last_beat` are both 1 removes the FIFO head. After that edge `cmpl_valid` is 1 for one cycle, and `cmpl_tag` equals the removed transfer's tag.
- R9: Completions come out in the order the transfers were taken, including when final beats arrive on back-to-back cycles.
- R10: `rd_done` while `rd_valid` is 0 has no effect, and `wr_last_beat` while `wr_valid` is 0 has no effect. Neither produces a completion, and neither changes the queue contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| req_valid | input | 1 | A transfer request is offered |
| req_ready | output | 1 | Program set is free to take a request |
| req_src_addr | input | TR_ADDR_W | Source address of the offered request |
| req_dst_addr | input | TR_ADDR_W | Destination address of the offered request |
| req_byte_cnt | input | TR_CNT_W | Byte count of the offered request |
| req_tag | input | TR_TAG_W | Tag of the offered request |
| prog_owned | output | 1 | Program set holds a request not yet promoted |
| rd_valid | output | 1 | Read context holds an active transfer |
| rd_src_addr | output | TR_ADDR_W | Source address of the active transfer |
| rd_byte_cnt | output | TR_CNT_W | Byte count of the active transfer |
| rd_tag | output | TR_TAG_W | Tag of the active transfer |
| rd_done | input | 1 | Read engine has finished the active transfer |
| wr_valid | output | 1 | Destination FIFO is not empty |
| wr_dst_addr | output | TR_ADDR_W | Destination address at the FIFO head |
| wr_byte_cnt | output | TR_CNT_W | Byte count at the FIFO head |
| wr_tag | output | TR_TAG_W | Tag at the FIFO head |
| wr_last_beat | input | 1 | Write engine accepted the last beat of the head transfer |
| cmpl_valid | output | 1 | Completion pulse |
| cmpl_tag | output | TR_TAG_W | Tag of the completed transfer |

## Verification
A wrong FIFO pointer or fill count shows up within one cycle of the next final beat, as a completion carrying the wrong tag or a head that shows the wrong transfer. A stray pop on an empty FIFO would only show later, when the next real transfer completes with a stale tag, so the bench follows ignored pulses with a fresh transfer. A fill count that is off by one shows as a program set that promotes one transfer too early or stays owned one transfer too long, and the bench watches `prog_owned` and the read context across the full-FIFO boundary.

// File: rtl/tr_stage_pkg.sv
package tr_stage_pkg;
  parameter int TR_ADDR_W = 32;
  parameter int TR_CNT_W  = 16;
  parameter int TR_TAG_W  = 4;

  // Full request as held in the program set
  typedef struct packed {
    logic [TR_ADDR_W-1:0] src_addr;
    logic [TR_ADDR_W-1:0] dst_addr;
    logic [TR_CNT_W-1:0]  byte_cnt;
    logic [TR_TAG_W-1:0]  tag;
  } tr_desc_t;

  // One-sided context: address, count, tag
  typedef struct packed {
    logic [TR_ADDR_W-1:0] addr;
    logic [TR_CNT_W-1:0]  byte_cnt;
    logic [TR_TAG_W-1:0]  tag;
  } tr_ctx_t;
endpackage

// File: rtl/tr_prog_set.sv
module tr_prog_set
  import tr_stage_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_valid,
  input  tr_desc_t wr_desc,
  input  logic     take,
  output logic     owned,
  output tr_desc_t desc
);
  logic     owned_q, owned_d;
  logic     load_en;
  tr_desc_t desc_q;

  assign load_en = wr_valid && !owned_q;

  always_comb begin
    owned_d = owned_q;
    if (take)    owned_d = 1'b0;
    if (load_en) owned_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owned_q <= 1'b0;
    else        owned_q <= owned_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) desc_q <= wr_desc;
  end

  assign owned = owned_q;
  assign desc  = desc_q;
endmodule

// File: rtl/tr_src_ctx.sv
module tr_src_ctx
  import tr_stage_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  tr_ctx_t load_ctx,
  input  logic    done,
  output logic    valid,
  output tr_ctx_t ctx
);
  logic    valid_q, valid_d;
  tr_ctx_t ctx_q;

  always_comb begin
    valid_d = valid_q;
    if (done) valid_d = 1'b0;
    if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) ctx_q <= load_ctx;
  end

  assign valid = valid_q;
  assign ctx   = ctx_q;
endmodule

// File: rtl/tr_dst_fifo.sv
module tr_dst_fifo
  import tr_stage_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  tr_ctx_t                    push_ctx,
  input  logic                       pop,
  output logic                       head_valid,
  output tr_ctx_t                    head,
  output logic [$clog2(DEPTH):0]     fill
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] n_q, n_d;
  tr_ctx_t          mem_q [DEPTH];

  always_comb begin
    wp_d = push ? wp_q + PTR_W'(1) : wp_q;
    rp_d = pop  ? rp_q + PTR_W'(1) : rp_q;
    n_d  = n_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      n_q  <= n_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = push && (wp_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (wr_en) mem_q[i] <= push_ctx;
    end
  end

  assign head_valid = (n_q != '0);
  assign head       = mem_q[rp_q];
  assign fill       = n_q;
endmodule

// File: rtl/tr_stage_queue.sv
module tr_stage_queue
  import tr_stage_pkg::*;
#(
  parameter int DFIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [TR_ADDR_W-1:0] req_src_addr,
  input  logic [TR_ADDR_W-1:0] req_dst_addr,
  input  logic [TR_CNT_W-1:0]  req_byte_cnt,
  input  logic [TR_TAG_W-1:0]  req_tag,
  output logic                 prog_owned,
  output logic                 rd_valid,
  output logic [TR_ADDR_W-1:0] rd_src_addr,
  output logic [TR_CNT_W-1:0]  rd_byte_cnt,
  output logic [TR_TAG_W-1:0]  rd_tag,
  input  logic                 rd_done,
  output logic                 wr_valid,
  output logic [TR_ADDR_W-1:0] wr_dst_addr,
  output logic [TR_CNT_W-1:0]  wr_byte_cnt,
  output logic [TR_TAG_W-1:0]  wr_tag,
  input  logic                 wr_last_beat,
  output logic                 cmpl_valid,
  output logic [TR_TAG_W-1:0]  cmpl_tag
);
  localparam int FILL_W = $clog2(DFIFO_DEPTH) + 1;

  tr_desc_t            in_desc, prog_desc;
  tr_ctx_t             src_load, dst_load, src_ctx, dst_head;
  logic                owned, promote, src_free, src_fin, dst_pop, dfifo_full;
  logic                src_valid, dst_valid;
  logic [FILL_W-1:0]   dfifo_fill;
  logic                cmpl_valid_q, cmpl_valid_d;
  logic [TR_TAG_W-1:0] cmpl_tag_q, cmpl_tag_d;

  assign in_desc = '{src_addr: req_src_addr, dst_addr: req_dst_addr,
                     byte_cnt: req_byte_cnt, tag: req_tag};

  // Promotion: program set full, read side free (or freeing now), FIFO has room
  assign src_fin    = rd_done && src_valid;
  assign src_free   = !src_valid || src_fin;
  assign dfifo_full = (dfifo_fill == FILL_W'(DFIFO_DEPTH));
  assign promote    = owned && src_free && !dfifo_full;
  assign dst_pop    = wr_last_beat && dst_valid;

  assign src_load = '{addr: prog_desc.src_addr, byte_cnt: prog_desc.byte_cnt, tag: prog_desc.tag};
  assign dst_load = '{addr: prog_desc.dst_addr, byte_cnt: prog_desc.byte_cnt, tag: prog_desc.tag};

  tr_prog_set u_prog (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (req_valid),
    .wr_desc  (in_desc),
    .take     (promote),
    .owned    (owned),
    .desc     (prog_desc)
  );

  tr_src_ctx u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (promote),
    .load_ctx (src_load),
    .done     (src_fin),
    .valid    (src_valid),
    .ctx      (src_ctx)
  );

  tr_dst_fifo #(.DEPTH(DFIFO_DEPTH)) u_dfifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (promote),
    .push_ctx   (dst_load),
    .pop        (dst_pop),
    .head_valid (dst_valid),
    .head       (dst_head),
    .fill       (dfifo_fill)
  );

  // Completion stage: one cycle after the final beat of the head
  always_comb begin
    cmpl_valid_d = dst_pop;
    cmpl_tag_d   = dst_pop ? dst_head.tag : cmpl_tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl_valid_q <= 1'b0;
      cmpl_tag_q   <= '0;
    end else begin
      cmpl_valid_q <= cmpl_valid_d;
      cmpl_tag_q   <= cmpl_tag_d;
    end
  end

  assign req_ready   = !owned;
  assign prog_owned  = owned;
  assign rd_valid    = src_valid;
  assign rd_src_addr = src_ctx.addr;
  assign rd_byte_cnt = src_ctx.byte_cnt;
  assign rd_tag      = src_ctx.tag;
  assign wr_valid    = dst_valid;
  assign wr_dst_addr = dst_head.addr;
  assign wr_byte_cnt = dst_head.byte_cnt;
  assign wr_tag      = dst_head.tag;
  assign cmpl_valid  = cmpl_valid_q;
  assign cmpl_tag    = cmpl_tag_q;
endmodule

// File: rtl/tr_stage_queue_chk.sv
module tr_stage_queue_chk
  import tr_stage_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      prog_owned,
  input logic                      rd_valid,
  input logic                      rd_done,
  input logic [TR_ADDR_W-1:0]      rd_src_addr,
  input logic                      wr_valid,
  input logic                      wr_last_beat,
  input logic [TR_TAG_W-1:0]       wr_tag,
  input logic                      cmpl_valid,
  input logic [TR_TAG_W-1:0]       cmpl_tag,
  input logic [$clog2(DEPTH):0]    dfifo_fill
);
  AST_ACCEPT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> prog_owned);                                  // R2
  AST_OWNED_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_owned |-> !req_ready);                                              // R3
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_done |=> rd_valid && $stable(rd_src_addr));              // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dfifo_fill <= ($clog2(DEPTH)+1)'(DEPTH));                                // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    prog_owned && dfifo_fill == ($clog2(DEPTH)+1)'(DEPTH) |=> prog_owned);   // R7
  AST_CMPL_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_last_beat |=> cmpl_valid);                                // R8
  AST_CMPL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> $past(wr_valid && wr_last_beat));                         // R10
  AST_CMPL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_last_beat |=> cmpl_tag == $past(wr_tag));                 // R9
endmodule

bind tr_stage_queue tr_stage_queue_chk #(.DEPTH(DFIFO_DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .prog_owned   (prog_owned),
  .rd_valid     (rd_valid),
  .rd_done      (rd_done),
  .rd_src_addr  (rd_src_addr),
  .wr_valid     (wr_valid),
  .wr_last_beat (wr_last_beat),
  .wr_tag       (wr_tag),
  .cmpl_valid   (cmpl_valid),
  .cmpl_tag     (cmpl_tag),
  .dfifo_fill   (dfifo_fill)
);

// File: tb/tr_stage_queue_bench.sv
`timescale 1ns/1ps
module tr_stage_queue_bench;
  import tr_stage_pkg::*;
  localparam int DEPTH = 4;

  logic                 clk, rst_n;
  logic                 req_valid, req_ready;
  logic [TR_ADDR_W-1:0] req_src_addr, req_dst_addr;
  logic [TR_CNT_W-1:0]  req_byte_cnt;
  logic [TR_TAG_W-1:0]  req_tag;
  logic                 prog_owned;
  logic                 rd_valid, rd_done;
  logic [TR_ADDR_W-1:0] rd_src_addr;
  logic [TR_CNT_W-1:0]  rd_byte_cnt;
  logic [TR_TAG_W-1:0]  rd_tag;
  logic                 wr_valid, wr_last_beat;
  logic [TR_ADDR_W-1:0] wr_dst_addr;
  logic [TR_CNT_W-1:0]  wr_byte_cnt;
  logic [TR_TAG_W-1:0]  wr_tag;
  logic                 cmpl_valid;
  logic [TR_TAG_W-1:0]  cmpl_tag;

  int n_run = 0;
  int n_fail = 0;

  tr_stage_queue #(.DFIFO_DEPTH(DEPTH)) u_tr_stage_queue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src_addr(req_src_addr), .req_dst_addr(req_dst_addr),
    .req_byte_cnt(req_byte_cnt), .req_tag(req_tag),
    .prog_owned(prog_owned),
    .rd_valid(rd_valid), .rd_src_addr(rd_src_addr), .rd_byte_cnt(rd_byte_cnt),
    .rd_tag(rd_tag), .rd_done(rd_done),
    .wr_valid(wr_valid), .wr_dst_addr(wr_dst_addr), .wr_byte_cnt(wr_byte_cnt),
    .wr_tag(wr_tag), .wr_last_beat(wr_last_beat),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [TR_ADDR_W-1:0] src_of(int t); return TR_ADDR_W'(32'h1000 * t); endfunction
  function automatic logic [TR_ADDR_W-1:0] dst_of(int t); return TR_ADDR_W'(32'h8000_0000 | (t << 8)); endfunction
  function automatic logic [TR_CNT_W-1:0]  cnt_of(int t); return TR_CNT_W'(t * 32); endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Offer a request for one edge; outputs are checked after that edge
  task automatic offer(int t);
    req_valid    = 1'b1;
    req_src_addr = src_of(t);
    req_dst_addr = dst_of(t);
    req_byte_cnt = cnt_of(t);
    req_tag      = TR_TAG_W'(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_rd_done();
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic chk_rd(string req, int t);
    chk(req, "rd_valid", rd_valid, 1);
    chk(req, "rd_tag", rd_tag, t);
    chk(req, "rd_src_addr", rd_src_addr, src_of(t));
    chk(req, "rd_byte_cnt", rd_byte_cnt, cnt_of(t));
  endtask

  task automatic chk_wr(string req, int t);
    chk(req, "wr_valid", wr_valid, 1);
    chk(req, "wr_tag", wr_tag, t);
    chk(req, "wr_dst_addr", wr_dst_addr, dst_of(t));
    chk(req, "wr_byte_cnt", wr_byte_cnt, cnt_of(t));
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "prog_owned", prog_owned, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "wr_valid", wr_valid, 0);
    chk("R1", "cmpl_valid", cmpl_valid, 0);
  endtask

  task automatic t_idle_promote();
    offer(1);
    chk("R2", "prog_owned", prog_owned, 1);
    chk("R2", "req_ready", req_ready, 0);
    chk("R4", "rd_valid early", rd_valid, 0);
    @(negedge clk);
    chk_rd("R4", 1);
    chk_wr("R4", 1);
    chk("R4", "prog_owned", prog_owned, 0);
  endtask

  task automatic t_backpressure_and_chain();
    offer(2);
    chk("R2", "prog_owned", prog_owned, 1);
    offer(3);                         // rejected while owned
    chk("R3", "prog_owned", prog_owned, 1);
    chk("R3", "req_ready", req_ready, 0);
    chk_rd("R5", 1);                  // held while rd_done low
    pulse_rd_done();
    chk_rd("R5", 2);                  // no idle cycle
    chk_wr("R6", 1);                  // head still oldest
    chk("R3", "prog_owned after", prog_owned, 0);
  endtask

  task automatic t_fill_full();
    offer(4);
    pulse_rd_done();
    chk_rd("R6", 4);
    offer(5);
    pulse_rd_done();
    chk_rd("R6", 5);
    chk_wr("R6", 1);
    offer(6);                         // FIFO now holds 1,2,4,5
    pulse_rd_done();                  // read side free, FIFO full
    chk("R7", "rd_valid", rd_valid, 0);
    chk("R7", "prog_owned", prog_owned, 1);
    repeat (3) @(negedge clk);
    chk("R7", "rd_valid held", rd_valid, 0);
    chk("R7", "prog_owned held", prog_owned, 1);
  endtask

  task automatic t_complete();
    wr_last_beat = 1'b1;
    @(negedge clk);
    wr_last_beat = 1'b0;
    chk("R8", "cmpl_valid", cmpl_valid, 1);
    chk("R8", "cmpl_tag", cmpl_tag, 1);
    chk_wr("R8", 2);
    @(negedge clk);
    chk("R8", "cmpl_valid pulse", cmpl_valid, 0);
    chk_rd("R7", 6);                  // released after room appeared
    chk("R7", "prog_owned", prog_owned, 0);
  endtask

  task automatic t_order();
    int exp_tags[4] = '{2, 4, 5, 6};
    wr_last_beat = 1'b1;
    foreach (exp_tags[i]) begin
      @(negedge clk);
      chk("R9", "cmpl_valid", cmpl_valid, 1);
      chk("R9", "cmpl_tag", cmpl_tag, exp_tags[i]);
    end
    wr_last_beat = 1'b0;
    chk("R9", "wr_valid drained", wr_valid, 0);
    pulse_rd_done();
    chk("R9", "rd_valid cleared", rd_valid, 0);
  endtask

  task automatic t_ignored();
    rd_done = 1'b1;
    wr_last_beat = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    wr_last_beat = 1'b0;
    chk("R10", "cmpl_valid", cmpl_valid, 0);
    chk("R10", "rd_valid", rd_valid, 0);
    chk("R10", "wr_valid", wr_valid, 0);
    @(negedge clk);
    chk("R10", "cmpl_valid later", cmpl_valid, 0);
    offer(7);
    @(negedge clk);
    chk_rd("R10", 7);
    chk_wr("R10", 7);
    wr_last_beat = 1'b1;
    @(negedge clk);
    wr_last_beat = 1'b0;
    chk("R10", "cmpl_tag", cmpl_tag, 7);
    chk("R10", "wr_valid empty", wr_valid, 0);
    chk("R3", "rejected tag never seen", (rd_tag == 3) || (cmpl_tag == 3), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_src_addr = '0; req_dst_addr = '0;
    req_byte_cnt = '0; req_tag = '0;
    rd_done = 1'b0; wr_last_beat = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_promote();
    t_backpressure_and_chain();
    t_fill_full();
    t_complete();
    t_order();
    t_ignored();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule